// File: doc/BRIEF.md
# Precise Exception Capture with Delay-Slot Awareness

This unit sits at the commit point of a scalar in-order pipeline whose branches and jumps have one architectural delay slot. Each cycle the commit stage presents at most one instruction, with its PC, a flag marking it as a branch or jump, and any fault it raised. The unit also takes an external interrupt line and a marker for a return-from-exception instruction. When an exception is taken, the unit records the restart address and the cause, sets the exception-level flag, and asks the rest of the pipeline to discard younger work and refetch from a fixed handler address.

The unit derives delay-slot status itself. It remembers whether the previously committed instruction was a branch or jump. If an instruction in a delay slot faults or is interrupted, the restart address is the branch before it (its PC minus 4), and the branch-delay flag in the cause word is set. The return path then re-executes the branch, and the branch resolves its target again. The unit keeps no other record of the interrupted branch. A return instruction reloads fetch from the saved restart address and clears the exception level.

Top module: `exc_capture_unit`

## Requirements
- R1: After reset, `epc`, `cause` and `exc_level` are zero, and `redirect_valid` and `flush` are low.
- R2: An exception on a committed instruction that is not in a delay slot stores its own PC in `epc` one cycle later and clears `cause[31]`.
- R3: An exception on the instruction committed right after a branch or jump stores that instruction's PC minus 4 in `epc` one cycle later and sets `cause[31]` (the branch-delay bit).
- R4: The exception code is written to `cause[6:2]`, and all other cause bits except bit 31 read zero. A breakpoint fault uses code 9.
- R5: One cycle after an exception is taken, `redirect_valid` and `flush` are high for exactly one cycle, `redirect_pc` equals the handler vector, and `exc_level` is 1.
- R6: An interrupt on a committing instruction is taken with code 0 and wins over a simultaneous fault. In a delay slot it restarts at the branch (`epc` = PC minus 4, bit 31 set).
- R7: A committed return instruction raises `redirect_valid` and `flush` one cycle later, with `redirect_pc` equal to the saved `epc`. It clears `exc_level` and leaves `epc` and `cause` unchanged.
- R8: Delay-slot status changes only when an instruction commits, so idle cycles between a branch and its slot do not lose it. Any flush (exception or return) clears it.
- R9: With `cmt_valid` low, `exc_req`, `irq` and `cmt_eret` have no effect: there is no redirect or flush, and `epc`, `cause` and `exc_level` keep their values.
- R10: If a fault and a return instruction commit in the same cycle, the exception is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_pc | input | 32 | PC of the committing instruction |
| cmt_is_branch | input | 1 | Committing instruction is a branch or jump |
| cmt_eret | input | 1 | Committing instruction is a return-from-exception |
| exc_req | input | 1 | Committing instruction raised a fault |
| exc_code | input | 5 | Fault code for `exc_req` |
| irq | input | 1 | External interrupt pending |
| epc | output | 32 | Saved restart address |
| cause | output | 32 | Cause word: bit 31 branch-delay, bits 6:2 code |
| exc_level | output | 1 | Exception level active |
| redirect_valid | output | 1 | Fetch redirect request (one-cycle pulse) |
| redirect_pc | output | 32 | Fetch redirect target |
| flush | output | 1 | Discard all younger instructions |

## Verification
The bench builds the unit with the handler vector moved to 0x0000_0F00, away from the default, so the redirect check can only pass if the parameter reaches the fetch target. Keeping the 32-bit data width places the delay-slot restart address at an exact PC-minus-4 boundary. The bench can then tell apart a faulting branch, its slot, a slot separated from its branch by idle cycles, and an interrupt arriving in a slot.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN     = 32;
    localparam int CODE_W   = 5;
    localparam int BD_POS   = XLEN - 1;
    localparam int CODE_LSB = 2;
    localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);
    localparam logic [CODE_W-1:0] CODE_INT  = '0;

    typedef struct packed {
        logic              bd;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   epc;
    } exc_rec_t;

    function automatic logic [XLEN-1:0] restart_addr(input logic [XLEN-1:0] pc,
                                                     input logic in_slot);
        return in_slot ? (pc - INSTR_BYTES) : pc;
    endfunction

    function automatic logic [XLEN-1:0] pack_cause(input logic bd,
                                                   input logic [CODE_W-1:0] code);
        logic [XLEN-1:0] c;
        c = '0;
        c[BD_POS] = bd;
        c[CODE_LSB +: CODE_W] = code;
        return c;
    endfunction
endpackage

// File: rtl/exc_slot_track.sv
module exc_slot_track
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmt_valid,
    input  logic cmt_is_branch,
    input  logic flush_now,
    output logic in_slot
);
    always_ff @(posedge clk) begin
        if (rst)            in_slot <= 1'b0;
        else if (flush_now) in_slot <= 1'b0;
        else if (cmt_valid) in_slot <= cmt_is_branch;
    end

    // R8
    slot_cleared_by_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush_now |=> !in_slot);
    // R8
    slot_held_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmt_valid && !flush_now) |=> $stable(in_slot));
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            ret,
    input  exc_rec_t        rec,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic            exc_level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc       <= '0;
            cause     <= '0;
            exc_level <= 1'b0;
        end else if (take) begin
            epc       <= rec.epc;
            cause     <= pack_cause(rec.bd, rec.code);
            exc_level <= 1'b1;
        end else if (ret) begin
            exc_level <= 1'b0;
        end
    end

    // R3
    bd_follows_record_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (cause[BD_POS] == $past(rec.bd)));
    // R7
    eret_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (ret && !take) |=> ($stable(epc) && $stable(cause) && !exc_level));
endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit
    import exc_pkg::*;
#(
    parameter logic [31:0] HANDLER_VEC = 32'h8000_0180
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmt_valid,
    input  logic [31:0]       cmt_pc,
    input  logic              cmt_is_branch,
    input  logic              cmt_eret,
    input  logic              exc_req,
    input  logic [4:0]        exc_code,
    input  logic              irq,
    output logic [31:0]       epc,
    output logic [31:0]       cause,
    output logic              exc_level,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc,
    output logic              flush
);
    logic     take, ret, in_slot;
    exc_rec_t rec;

    always_comb begin
        take     = cmt_valid && (exc_req || irq);
        ret      = cmt_valid && cmt_eret && !take;
        rec.bd   = in_slot;
        rec.code = irq ? CODE_INT : exc_code;
        rec.epc  = restart_addr(cmt_pc, in_slot);
    end

    exc_slot_track u_track (
        .clk          (clk),
        .rst          (rst),
        .cmt_valid    (cmt_valid),
        .cmt_is_branch(cmt_is_branch),
        .flush_now    (take || ret),
        .in_slot      (in_slot)
    );

    exc_state_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .ret      (ret),
        .rec      (rec),
        .epc      (epc),
        .cause    (cause),
        .exc_level(exc_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            flush          <= 1'b0;
        end else begin
            redirect_valid <= take || ret;
            flush          <= take || ret;
            if (take)     redirect_pc <= HANDLER_VEC;
            else if (ret) redirect_pc <= epc;
        end
    end

    // R5
    vector_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (redirect_valid && flush && redirect_pc == HANDLER_VEC && exc_level));
    // R9
    idle_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        !cmt_valid |=> (!redirect_valid && !flush));
    // R7
    eret_target_chk: assert property (@(posedge clk) disable iff (rst)
        ret |=> (redirect_valid && redirect_pc == $past(epc)));
endmodule

// File: tb/tb_exc_capture_unit.sv
module tb_exc_capture_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VEC = 32'h0000_0F00;

    logic        clk = 0, rst = 1;
    logic        cmt_valid = 0, cmt_is_branch = 0, cmt_eret = 0, exc_req = 0, irq = 0;
    logic [31:0] cmt_pc = '0;
    logic [4:0]  exc_code = '0;
    logic [31:0] epc, cause, redirect_pc;
    logic        exc_level, redirect_valid, flush;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    exc_capture_unit #(.HANDLER_VEC(VEC)) dut (
        .clk(clk), .rst(rst), .cmt_valid(cmt_valid), .cmt_pc(cmt_pc),
        .cmt_is_branch(cmt_is_branch), .cmt_eret(cmt_eret), .exc_req(exc_req),
        .exc_code(exc_code), .irq(irq), .epc(epc), .cause(cause),
        .exc_level(exc_level), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .flush(flush));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one commit for one cycle; returns at the next falling edge,
    // where the registered results of that commit are visible.
    task automatic commit(input logic [31:0] pc, input logic br, input logic ex,
                          input logic [4:0] code, input logic intr, input logic er);
        @(negedge clk);
        cmt_valid = 1; cmt_pc = pc; cmt_is_branch = br; exc_req = ex;
        exc_code = code; irq = intr; cmt_eret = er;
        @(negedge clk);
        cmt_valid = 0; cmt_is_branch = 0; exc_req = 0; irq = 0; cmt_eret = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 epc", epc, 0);
        chk("R1 cause", cause, 0);
        chk("R1 level/redirect/flush", {29'd0, exc_level, redirect_valid, flush}, 0);
    endtask

    task automatic t_plain_break;
        commit(32'h100, 0, 1, 5'd9, 0, 0);
        chk("R2 epc", epc, 32'h100);
        chk("R4 cause code9 bd0", cause, 32'h0000_0024);
        chk("R5 redirect/flush/level", {29'd0, redirect_valid, flush, exc_level}, 3'b111);
        chk("R5 vector", redirect_pc, VEC);
        idle(1);
        chk("R5 one-cycle pulse", {30'd0, redirect_valid, flush}, 0);
    endtask

    task automatic t_eret;
        commit(32'hF10, 0, 0, 0, 0, 1);
        chk("R7 redirect to epc", redirect_pc, 32'h100);
        chk("R7 valid/flush/level", {29'd0, redirect_valid, flush, exc_level}, 3'b110);
        chk("R7 epc kept", epc, 32'h100);
        chk("R7 cause kept", cause, 32'h0000_0024);
    endtask

    task automatic t_slot;
        commit(32'h200, 1, 0, 0, 0, 0);
        commit(32'h204, 0, 1, 5'd4, 0, 0);
        chk("R3 epc = branch", epc, 32'h200);
        chk("R3 R4 cause bd+code4", cause, 32'h8000_0010);
    endtask

    task automatic t_gap;
        commit(32'h300, 1, 0, 0, 0, 0);
        idle(3);
        commit(32'h304, 0, 1, 5'd10, 0, 0);
        chk("R8 slot survives idle epc", epc, 32'h300);
        chk("R8 slot survives idle bd", cause, 32'h8000_0028);
    endtask

    task automatic t_flush_clears;
        commit(32'h400, 1, 1, 5'd12, 0, 0);
        chk("R2 faulting branch epc", epc, 32'h400);
        chk("R2 faulting branch bd0", cause, 32'h0000_0030);
        commit(32'h500, 0, 1, 5'd12, 0, 0);
        chk("R8 flush cleared slot epc", epc, 32'h500);
        chk("R8 flush cleared slot bd", cause, 32'h0000_0030);
    endtask

    task automatic t_irq_slot;
        commit(32'h600, 1, 0, 0, 0, 0);
        commit(32'h604, 0, 1, 5'd12, 1, 0);
        chk("R6 irq epc = branch", epc, 32'h600);
        chk("R6 irq code0 bd1", cause, 32'h8000_0000);
        chk("R6 redirect vector", redirect_pc, VEC);
    endtask

    task automatic t_ignored;
        @(negedge clk);
        exc_req = 1; exc_code = 5'd7; irq = 1; cmt_eret = 1; cmt_pc = 32'h999;
        @(negedge clk);
        chk("R9 no redirect", {30'd0, redirect_valid, flush}, 0);
        exc_req = 0; irq = 0; cmt_eret = 0;
        chk("R9 epc kept", epc, 32'h600);
        chk("R9 cause kept", cause, 32'h8000_0000);
        chk("R9 level kept", {31'd0, exc_level}, 1);
    endtask

    task automatic t_prio;
        commit(32'hF20, 0, 0, 0, 0, 1);
        chk("R7 level cleared", {31'd0, exc_level}, 0);
        commit(32'h700, 0, 1, 5'd13, 0, 1);
        chk("R10 exception wins target", redirect_pc, VEC);
        chk("R10 epc", epc, 32'h700);
        chk("R10 level set", {31'd0, exc_level}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_plain_break();
        t_eret();
        t_slot();
        t_gap();
        t_flush_clears();
        t_irq_slot();
        t_ignored();
        t_prio();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule